// File: doc/BRIEF.md
# SD Host Command Issue and Response Capture

This block sends one SD command at a time on behalf of software and records what the card returns. Software programs a 32-bit argument and then writes a control word. The control word carries the 6-bit command index, a start bit, a flag that says a response is expected and a flag that selects a long response. The start write sends a one-cycle request, with the index and argument, to the card-side engine. That engine is outside this block and handles CRC and the serial CMD line.

The card side answers with a stream of response bytes and then an end strobe. The end strobe may carry a no-response qualifier. The block packs the bytes into four 32-bit response words, first byte at the most significant position. It checks the byte count against the expected length and sets a completion or timeout flag in a 13-bit status word. That word also echoes the command index and a command-sent flag. The three event flags are write-1-to-clear. Each one drives a level-sensitive interrupt line through its own enable bit.

The register bus has a 2-bit word address: 0 is control, 1 is argument, 2 is status (write-1-to-clear), 3 is the interrupt enable word.

Top module: `sd_cmd_host`

## Requirements
- R1: A control write (address 0) with bit 8 set, made while no response is awaited, produces `cardReq` high for exactly the one cycle after the write. `cardIdx` shows bits 5:0 of that write and `cardArg` shows the last argument written (address 1).
- R2: On that start, status bits 5:0 take the command index, bits 8:6 and 12 read 0, bit 11 (command sent) is set, and bits 10:9 keep their earlier values.
- R3: All four response words read zero after a start, before any response byte arrives.
- R4: A command whose control bit 9 (response expected) is 0 completes with the request. `busy` stays low, status bits 10:9 are unchanged, and card bytes or end strobes that arrive afterwards change nothing.
- R5: Response byte i (counting from 0) is written to word i/4 at bits 8*(3 - i mod 4) + 7 down to 8*(3 - i mod 4). Word 0 is `rspWords[31:0]`. Bytes beyond the sixteenth are dropped.
- R6: The expected length is 16 bytes when control bit 10 is set and 6 bytes otherwise. At the end strobe, a matching count sets status bit 9. A count that does not match, or an end strobe with `cardNoRsp` high, sets status bit 10 instead. `busy` is high from the start until the cycle after the end strobe.
- R7: A write to the status word (address 2) clears those bits among 12:9 that are 1 in the written value, and no others. An event that sets a flag in the same cycle wins over the clear.
- R8: `irq` is high exactly while (enable bit 0 and status bit 11) or (enable bit 1 and status bit 9) or (enable bit 2 and status bit 10) holds, where the enable word is written at address 3.
- R9: A control write made while a response is awaited is discarded entirely. There is no new request, and the index and the pending command stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word address |
| wrData | input | 32 | Register write data |
| cardReq | output | 1 | One-cycle command request to the card engine |
| cardIdx | output | 6 | Command index of the request |
| cardArg | output | 32 | Command argument of the request |
| rxValid | input | 1 | Response byte valid |
| rxByte | input | 8 | Response byte |
| rxEnd | input | 1 | End of response strobe |
| cardNoRsp | input | 1 | Qualifies `rxEnd`: the card gave no response |
| busy | output | 1 | A response is being awaited |
| rspWords | output | 128 | Four response words, word 0 in bits 31:0 |
| cmdStatus | output | 13 | Command status word |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default lengths: 16 bytes for a long response and 6 for a short one. These values reach the full four-word packing and the two-word partial packing of a short response. A long stream of 18 bytes reaches the drop of bytes beyond the sixteenth and the mismatch timeout that follows. Random commands vary the index, argument, enables, response kind and byte count. Directed cases cover a start write made while busy, a command with no response followed by stray card traffic, and a status clear in the same cycle as a completion.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int ADDR_W = 2;
  localparam int STAT_W = 13;
  localparam int IDX_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ARG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd3;

  localparam int BIT_START = 8;
  localparam int BIT_WAIT  = 9;
  localparam int BIT_LONG  = 10;
  localparam int ST_RSPFIN = 9;
  localparam int ST_TOUT   = 10;
  localparam int ST_SENT   = 11;
  localparam logic [STAT_W-1:0] W1C_MASK = 13'h1e00;

  typedef enum logic {S_IDLE, S_WAIT} cmdState_t;

  typedef struct packed {
    logic             ctrlWr;
    logic             startCmd;
    logic             capByte;
    logic [IDX_W-1:0] byteIdx;
    logic             finOk;
    logic             finTout;
  } cmdStrobe_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int LONG_BYTES  = 16,
  parameter int SHORT_BYTES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rxValid,
  input  logic              rxEnd,
  input  logic              cardNoRsp,
  output logic              cardReq,
  output logic              busy,
  output cmdStrobe_t        strobe
);
  localparam int CNT_W = $clog2(LONG_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(LONG_BYTES + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_BYTES);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_BYTES);

  cmdState_t       state;
  logic [CNT_W-1:0] byteCnt;
  logic             expLong;
  logic             endEvt;

  always_comb begin
    strobe          = '0;
    strobe.ctrlWr   = wrEn && (wrAddr == ADDR_CTRL) && (state == S_IDLE);
    strobe.startCmd = strobe.ctrlWr && wrData[BIT_START];
    strobe.capByte  = (state == S_WAIT) && rxValid && (byteCnt < LEN_LONG);
    strobe.byteIdx  = IDX_W'(byteCnt);
    endEvt          = (state == S_WAIT) && rxEnd;
    if (endEvt) begin
      if (!cardNoRsp && byteCnt == (expLong ? LEN_LONG : LEN_SHORT))
        strobe.finOk = 1'b1;
      else
        strobe.finTout = 1'b1;
    end
  end

  assign busy = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteCnt <= '0;
      expLong <= 1'b0;
      cardReq <= 1'b0;
    end else begin
      cardReq <= strobe.startCmd;
      if (strobe.startCmd) begin
        byteCnt <= '0;
        expLong <= wrData[BIT_LONG];
        state   <= wrData[BIT_WAIT] ? S_WAIT : S_IDLE;
      end else if (endEvt) begin
        state <= S_IDLE;
      end else if (state == S_WAIT && rxValid && byteCnt != CNT_SAT) begin
        byteCnt <= byteCnt + 1'b1;
      end
    end
  end

  // R1: the card request is a single-cycle pulse
  p_req_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    cardReq |=> !cardReq);
  // R6: a command ends in exactly one of completion or timeout
  p_fin_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finOk && strobe.finTout));
  // R9: a control write while waiting leaves the pending command in place
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrAddr == ADDR_CTRL && !rxEnd) |=> (busy && !cardReq));
  // R6: busy drops right after the end strobe
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rxEnd) |=> !busy);
endmodule

// File: rtl/sd_cmd_datapath.sv
module sd_cmd_datapath
  import sd_cmd_pkg::*;
#(
  parameter int LONG_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [31:0]              wrData,
  input  logic [7:0]               rxByte,
  input  cmdStrobe_t               strobe,
  output logic [5:0]               cardIdx,
  output logic [31:0]              cardArg,
  output logic [LONG_BYTES*8-1:0]  rspWords,
  output logic [STAT_W-1:0]        cmdStatus,
  output logic                     irq
);
  localparam int NUM_WORDS = LONG_BYTES / 4;

  logic [12:0]       ctrlReg;
  logic [31:0]       argReg;
  logic [2:0]        maskReg;
  logic [STAT_W-1:0] statReg;
  logic [STAT_W-1:0] statNext;
  logic [31:0]       rspReg [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      argReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.ctrlWr) ctrlReg <= wrData[12:0];
      if (wrEn && wrAddr == ADDR_ARG) argReg <= wrData;
      if (wrEn && wrAddr == ADDR_MASK) maskReg <= wrData[2:0];
    end
  end

  always_comb begin
    statNext = statReg;
    if (wrEn && wrAddr == ADDR_STAT)
      statNext = statNext & ~(wrData[STAT_W-1:0] & W1C_MASK);
    if (strobe.startCmd)
      statNext = {1'b0, 1'b1, statNext[ST_TOUT:ST_RSPFIN], 3'b000, wrData[5:0]};
    if (strobe.finOk)   statNext[ST_RSPFIN] = 1'b1;
    if (strobe.finTout) statNext[ST_TOUT]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= statNext;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rstN || strobe.startCmd) begin
        rspReg[w] <= '0;
      end else if (strobe.capByte && (strobe.byteIdx >> 2) == IDX_W'(w)) begin
        rspReg[w] <= rspReg[w] |
          ({24'd0, rxByte} << (5'(3 - int'(strobe.byteIdx[1:0])) * 5'd8));
      end
    end
    assign rspWords[w*32 +: 32] = rspReg[w];
  end

  assign cardIdx   = ctrlReg[5:0];
  assign cardArg   = argReg;
  assign cmdStatus = statReg;
  assign irq = (maskReg[0] & statReg[ST_SENT]) | (maskReg[1] & statReg[ST_RSPFIN]) |
               (maskReg[2] & statReg[ST_TOUT]);

  // R2: a start echoes the index and flags the command as sent
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startCmd |=> (statReg[ST_SENT] && statReg[5:0] == cardIdx && statReg[8:6] == 3'b0));
  // R3: response words are cleared by a start
  p_rsp_cleared_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startCmd |=> (rspWords == '0));
  // R7: a status write clears bit 9 unless a completion coincides
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_STAT && wrData[ST_RSPFIN] && !strobe.finOk) |=> !statReg[ST_RSPFIN]);
  // R8: the interrupt only rises after an event or an enable write
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strobe.startCmd || strobe.finOk || strobe.finTout ||
                         (wrEn && wrAddr == ADDR_MASK)));
endmodule

// File: rtl/sd_cmd_host.sv
module sd_cmd_host
  import sd_cmd_pkg::*;
#(
  parameter int LONG_BYTES  = 16,
  parameter int SHORT_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [1:0]              wrAddr,
  input  logic [31:0]             wrData,
  output logic                    cardReq,
  output logic [5:0]              cardIdx,
  output logic [31:0]             cardArg,
  input  logic                    rxValid,
  input  logic [7:0]              rxByte,
  input  logic                    rxEnd,
  input  logic                    cardNoRsp,
  output logic                    busy,
  output logic [LONG_BYTES*8-1:0] rspWords,
  output logic [12:0]             cmdStatus,
  output logic                    irq
);
  cmdStrobe_t strobe;

  sd_cmd_ctrl #(.LONG_BYTES(LONG_BYTES), .SHORT_BYTES(SHORT_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxValid(rxValid), .rxEnd(rxEnd), .cardNoRsp(cardNoRsp),
    .cardReq(cardReq), .busy(busy), .strobe(strobe));

  sd_cmd_datapath #(.LONG_BYTES(LONG_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxByte(rxByte), .strobe(strobe), .cardIdx(cardIdx), .cardArg(cardArg),
    .rspWords(rspWords), .cmdStatus(cmdStatus), .irq(irq));
endmodule

// File: tb/sd_cmd_host_test.sv
module sd_cmd_host_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         rxValid = 1'b0;
  logic [7:0]   rxByte = '0;
  logic         rxEnd = 1'b0;
  logic         cardNoRsp = 1'b0;
  logic         cardReq, busy, irq;
  logic [5:0]   cardIdx;
  logic [31:0]  cardArg;
  logic [127:0] rspWords;
  logic [12:0]  cmdStatus;

  int checks = 0;
  int errors = 0;
  logic [12:0] expStat = '0;
  logic [2:0]  expMask = '0;
  logic [7:0]  bytesSent [20];

  sd_cmd_host uut (.*);

  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic expIrq(input logic [2:0] m, input logic [12:0] s);
    return (m[0] & s[11]) | (m[1] & s[9]) | (m[2] & s[10]);
  endfunction

  function automatic logic [127:0] packRsp(input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < n && i < 16; i++)
      r[(i / 4) * 32 + 8 * (3 - i % 4) +: 8] = bytesSent[i];
    return r;
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendEnd(input logic noRsp);
    @(negedge clk);
    rxEnd = 1'b1; cardNoRsp = noRsp;
    @(negedge clk);
    rxEnd = 1'b0; cardNoRsp = 1'b0;
  endtask

  task automatic startCmd(input logic [5:0] idx, input logic waitR, input logic longR);
    regWrite(2'd0, {19'd0, 2'b00, longR, waitR, 1'b1, 2'b00, idx});
    expStat = {1'b0, 1'b1, expStat[10:9], 3'b000, idx};
    check("R1 cardReq", cardReq, 1'b1);
    check("R1 cardIdx", cardIdx, idx);
    check("R2 status", cmdStatus, expStat);
    check("R3 rsp cleared", rspWords, '0);
    check("R6 busy", busy, waitR);
    @(negedge clk);
    check("R1 single pulse", cardReq, 1'b0);
  endtask

  initial begin
    logic [31:0] arg;
    repeat (3) @(negedge clk);
    check("R2 reset status", cmdStatus, '0);
    check("R8 reset irq", irq, 1'b0);
    check("R6 reset busy", busy, 1'b0);
    rstN = 1'b1;

    // Directed: long response with a full count
    regWrite(2'd1, 32'hCAFE_0123);
    check("R1 cardArg", cardArg, 32'hCAFE_0123);
    regWrite(2'd3, 32'h7); expMask = 3'h7;
    check("R8 irq after enable", irq, expIrq(expMask, expStat));
    startCmd(6'd2, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) begin
      bytesSent[i] = 8'(8'h10 + i);
      sendByte(bytesSent[i]);
    end
    check("R5 long packing", rspWords, packRsp(16));
    check("R5 word0 msb first", rspWords[31:0], 32'h1011_1213);

    // R9: control write while busy is discarded
    regWrite(2'd0, 32'h0000_073F);
    check("R9 no request while busy", cardReq, 1'b0);
    check("R9 index kept", cardIdx, 6'd2);
    check("R9 still busy", busy, 1'b1);
    sendEnd(1'b0);
    expStat[9] = 1'b1;
    check("R6 long ok", cmdStatus, expStat);
    check("R6 idle after end", busy, 1'b0);
    check("R8 irq", irq, expIrq(expMask, expStat));

    // R7: clear only bit 9 plus non-W1C bits written as ones
    regWrite(2'd2, 32'h0000_01FF | 32'h200);
    expStat[9] = 1'b0;
    check("R7 partial clear", cmdStatus, expStat);

    // R4: command without response, then stray card traffic
    startCmd(6'd0, 1'b0, 1'b0);
    sendByte(8'hAA);
    sendEnd(1'b1);
    check("R4 rsp untouched", rspWords, '0);
    check("R4 status untouched", cmdStatus, expStat);

    // R5/R6: long stream of 18 bytes, extra dropped and timeout
    startCmd(6'd9, 1'b1, 1'b1);
    for (int i = 0; i < 18; i++) begin
      bytesSent[i] = 8'($urandom);
      sendByte(bytesSent[i]);
    end
    sendEnd(1'b0);
    expStat[10] = 1'b1;
    check("R5 overflow dropped", rspWords, packRsp(16));
    check("R6 overflow timeout", cmdStatus, expStat);

    // R7: set wins over a same-cycle clear
    regWrite(2'd2, 32'h1E00); expStat[12:9] = '0;
    check("R7 clear all", cmdStatus, expStat);
    startCmd(6'd17, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      bytesSent[i] = 8'(8'hA0 + i);
      sendByte(bytesSent[i]);
    end
    @(negedge clk);
    rxEnd = 1'b1; wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'h0000_0200;
    @(negedge clk);
    rxEnd = 1'b0; wrEn = 1'b0;
    expStat[9] = 1'b1;
    check("R7 set wins", cmdStatus, expStat);
    check("R5 short packing", rspWords, packRsp(6));

    // Random commands
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      logic [5:0] idx;
      logic waitR, longR;
      int kind, n;
      idx = 6'($urandom); waitR = ($urandom % 4) != 0; longR = 1'($urandom);
      kind = $urandom % 3;
      arg = $urandom;
      regWrite(2'd1, arg);
      expMask = 3'($urandom); regWrite(2'd3, {29'd0, expMask});
      if ($urandom % 2) begin
        logic [3:0] clr = 4'($urandom);
        regWrite(2'd2, {19'd0, clr, 9'h1FF});
        expStat[12:9] = expStat[12:9] & ~clr;
        check("R7 random clear", cmdStatus, expStat);
      end
      startCmd(idx, waitR, longR);
      check("R1 random arg", cardArg, arg);
      if (!waitR) begin
        check("R4 random no-rsp", cmdStatus, expStat);
        check("R8 random irq", irq, expIrq(expMask, expStat));
        continue;
      end
      n = longR ? 16 : 6;
      if (kind == 1) n = ($urandom % 2) ? n - 1 : n + 1;
      for (int i = 0; i < n; i++) begin
        bytesSent[i] = 8'($urandom);
        sendByte(bytesSent[i]);
      end
      sendEnd(kind == 2);
      if (kind == 0) expStat[9] = 1'b1;
      else           expStat[10] = 1'b1;
      check("R5 random packing", rspWords, packRsp(n));
      check("R6 random status", cmdStatus, expStat);
      check("R8 random irq", irq, expIrq(expMask, expStat));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule